// File: doc/BRIEF.md
# Shift Rotate Unit with Flags

This block is the bit-movement stage of a small microcontroller datapath. It is purely combinational. It takes one operand byte, the carry flag currently held in the status register and a 3-bit operation code. From these it returns the moved byte, fresh zero, carry, negative and overflow flag values, and a write-enable mask. The mask tells the status register which of those flags it should capture.

The unit supports six operations:

- shifts: one-bit arithmetic right, logical left and logical right;
- rotates: left and right through the carry, so the old carry enters the byte and the bit pushed out becomes the new carry;
- nibble swap: exchanges the two halves of the byte and leaves every flag alone.

The surrounding decoder picks the operation. The register file supplies the operand and takes the result. The status register applies the mask.

Top module: `srf_unit`

## Requirements
- R1: Operation code 0 (arithmetic right): result bit 7 keeps operand bit 7, result bit i is operand bit i+1 for i = 0..6, and carry out is operand bit 0.
- R2: Operation code 1 (logical left): result bit i+1 is operand bit i, result bit 0 is 0, and carry out is operand bit 7.
- R3: Operation code 2 (logical right): result bit i is operand bit i+1, result bit 7 is 0, and carry out is operand bit 0.
- R4: Operation code 3 (rotate left through carry): result bit i+1 is operand bit i, result bit 0 is carry in, and carry out is operand bit 7.
- R5: Operation code 4 (rotate right through carry): result bit i is operand bit i+1, result bit 7 is carry in, and carry out is operand bit 0.
- R6: Operation code 5 (nibble swap): the result is {operand[3:0], operand[7:4]}, carry out equals carry in, and the flag write mask is 4'b0000.
- R7: For every operation code, the zero flag output is 1 exactly when the 8-bit result is 0x00.
- R8: For every operation code, the negative flag output equals result bit 7.
- R9: For every operation code, the overflow flag output is the exclusive-or of the new negative flag and the new carry flag.
- R10: For operation codes 0 to 4, the flag write mask is 4'b1111. Mask bit 3 enables V, bit 2 enables N, bit 1 enables Z and bit 0 enables C.
- R11: Operation codes 6 and 7 are unused. The result equals the operand, carry out equals carry in, and the flag write mask is 4'b0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_i | input | 8 | Operand byte |
| cin_i | input | 1 | Carry flag from the status register |
| op_i | input | 3 | Operation code (0 to 5 used) |
| res_o | output | 8 | Moved byte |
| flag_c_o | output | 1 | New carry value |
| flag_z_o | output | 1 | New zero value |
| flag_n_o | output | 1 | New negative value |
| flag_v_o | output | 1 | New overflow value |
| flag_we_o | output | 4 | Flag write mask {V,N,Z,C} |

## Verification
On a rotate, two things happen in the same evaluation: the incoming carry is fed into the byte, and the bit shifted out becomes the new carry. The overflow flag is then formed from that new carry together with the new bit 7. A right rotate with carry in set makes the new negative flag depend on the old carry, while the new carry depends on the operand's low bit. A left rotate of 0x80 with carry in clear gives a zero result, with the carry and overflow flags both set. Every operation code is swept over all operand bytes and both carry-in values, and each flag is compared with a model written from the requirements.

// File: rtl/srf_pkg.sv
package srf_pkg;
  localparam int unsigned OP_W = 3;
  localparam int unsigned FLAG_N_BITS = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ASR  = 3'd0,
    OP_LSL  = 3'd1,
    OP_LSR  = 3'd2,
    OP_ROL  = 3'd3,
    OP_ROR  = 3'd4,
    OP_SWAP = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } srf_op_e;

  // Mask bit positions {V,N,Z,C}
  localparam int unsigned FB_C = 0;
  localparam int unsigned FB_Z = 1;
  localparam int unsigned FB_N = 2;
  localparam int unsigned FB_V = 3;
endpackage

// File: rtl/srf_shift_core.sv
module srf_shift_core
  import srf_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] opnd,
  input  logic             cin,
  input  srf_op_e          op,
  output logic [WIDTH-1:0] res,
  output logic             cout,
  output logic             upd
);
  localparam int unsigned HALF = WIDTH / 2;

  logic             fill_hi;
  logic             fill_lo;
  logic [WIDTH-1:0] move_dn;
  logic [WIDTH-1:0] move_up;
  logic [WIDTH-1:0] swapped;

  // Bit entering at the top on right moves, at the bottom on left moves
  always_comb begin
    unique case (op)
      OP_ASR:  fill_hi = opnd[WIDTH-1];
      OP_ROR:  fill_hi = cin;
      default: fill_hi = 1'b0;
    endcase
    fill_lo = (op == OP_ROL) ? cin : 1'b0;
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_lane
    if (i == WIDTH - 1) begin : g_top
      assign move_dn[i] = fill_hi;
    end else begin : g_mid_dn
      assign move_dn[i] = opnd[i+1];
    end
    if (i == 0) begin : g_bot
      assign move_up[i] = fill_lo;
    end else begin : g_mid_up
      assign move_up[i] = opnd[i-1];
    end
  end

  assign swapped = {opnd[HALF-1:0], opnd[WIDTH-1:HALF]};

  always_comb begin
    res  = opnd;
    cout = cin;
    upd  = 1'b0;
    unique case (op)
      OP_ASR, OP_LSR, OP_ROR: begin
        res  = move_dn;
        cout = opnd[0];
        upd  = 1'b1;
      end
      OP_LSL, OP_ROL: begin
        res  = move_up;
        cout = opnd[WIDTH-1];
        upd  = 1'b1;
      end
      OP_SWAP: res = swapped;
      default: ;
    endcase
  end
endmodule

// File: rtl/srf_flag_gen.sv
module srf_flag_gen
  import srf_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0]       res,
  input  logic                   cout,
  input  logic                   upd,
  output logic                   z,
  output logic                   n,
  output logic                   v,
  output logic [FLAG_N_BITS-1:0] we
);
  always_comb begin
    z  = ~|res;
    n  = res[WIDTH-1];
    v  = n ^ cout;
    we = {FLAG_N_BITS{upd}};
  end
endmodule

// File: rtl/srf_unit.sv
module srf_unit
  import srf_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] opnd_i,
  input  logic             cin_i,
  input  logic [2:0]       op_i,
  output logic [WIDTH-1:0] res_o,
  output logic             flag_c_o,
  output logic             flag_z_o,
  output logic             flag_n_o,
  output logic             flag_v_o,
  output logic [3:0]       flag_we_o
);
  srf_op_e op_sel;
  logic    upd;

  assign op_sel = srf_op_e'(op_i);

  srf_shift_core #(.WIDTH(WIDTH)) u_core (
    .opnd (opnd_i),
    .cin  (cin_i),
    .op   (op_sel),
    .res  (res_o),
    .cout (flag_c_o),
    .upd  (upd)
  );

  srf_flag_gen #(.WIDTH(WIDTH)) u_flags (
    .res  (res_o),
    .cout (flag_c_o),
    .upd  (upd),
    .z    (flag_z_o),
    .n    (flag_n_o),
    .v    (flag_v_o),
    .we   (flag_we_o)
  );
endmodule

// File: rtl/srf_unit_chk.sv
module srf_unit_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic [WIDTH-1:0] opnd_i,
  input logic             cin_i,
  input logic [2:0]       op_i,
  input logic [WIDTH-1:0] res_o,
  input logic             flag_c_o,
  input logic             flag_z_o,
  input logic             flag_n_o,
  input logic             flag_v_o,
  input logic [3:0]       flag_we_o
);
  logic known;
  assign known = !$isunknown({opnd_i, cin_i, op_i});

  always_comb begin
    if (known && op_i == 3'd0)
      a_r1_asr_keeps_sign: assert (res_o[WIDTH-1] == opnd_i[WIDTH-1] && flag_c_o == opnd_i[0])
        else $error("R1 sign or carry wrong");
    if (known && op_i == 3'd1)
      a_r2_lsl_clears_lsb: assert (!res_o[0] && flag_c_o == opnd_i[WIDTH-1])
        else $error("R2 lsb or carry wrong");
    if (known && op_i == 3'd1)
      a_r7_lsl_zero: assert (flag_z_o == (opnd_i[WIDTH-2:0] == '0))
        else $error("R7 zero after left shift wrong");
    if (known && op_i == 3'd3)
      a_r4_rol_carry_in: assert (res_o[0] == cin_i && flag_c_o == opnd_i[WIDTH-1])
        else $error("R4 rotate left wrong");
    if (known && op_i == 3'd4)
      a_r8_ror_neg_from_cin: assert (flag_n_o == cin_i && flag_c_o == opnd_i[0])
        else $error("R8 rotate right negative wrong");
    if (known && op_i == 3'd5)
      a_r6_swap_no_update: assert (flag_we_o == 4'b0000 && flag_c_o == cin_i)
        else $error("R6 swap touched flags");
    if (known && op_i < 3'd5)
      a_r10_full_mask: assert (flag_we_o == 4'b1111)
        else $error("R10 mask not full");
    if (known && op_i > 3'd5)
      a_r11_unused_pass: assert (res_o == opnd_i && flag_we_o == 4'b0000)
        else $error("R11 unused code not passive");
    if (known && op_i == 3'd2)
      a_r9_lsr_v_is_c: assert (flag_v_o == opnd_i[0])
        else $error("R9 overflow after right shift wrong");
  end
endmodule

bind srf_unit srf_unit_chk #(.WIDTH(WIDTH)) u_chk (
  .opnd_i    (opnd_i),
  .cin_i     (cin_i),
  .op_i      (op_i),
  .res_o     (res_o),
  .flag_c_o  (flag_c_o),
  .flag_z_o  (flag_z_o),
  .flag_n_o  (flag_n_o),
  .flag_v_o  (flag_v_o),
  .flag_we_o (flag_we_o)
);

// File: tb/tb_srf_unit.sv
`timescale 1ns/1ps
module tb_srf_unit;
  logic       clk;
  logic       rst_n;
  logic [7:0] opnd_i;
  logic       cin_i;
  logic [2:0] op_i;
  logic [7:0] res_o;
  logic       flag_c_o, flag_z_o, flag_n_o, flag_v_o;
  logic [3:0] flag_we_o;

  typedef struct {
    logic [7:0] res;
    logic       c, z, n, v;
    logic [3:0] we;
    string      tag;
    string      we_tag;
  } exp_t;

  exp_t q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   drive_done = 0;
  int   cyc = 0;

  srf_unit dut (
    .opnd_i(opnd_i), .cin_i(cin_i), .op_i(op_i), .res_o(res_o),
    .flag_c_o(flag_c_o), .flag_z_o(flag_z_o), .flag_n_o(flag_n_o),
    .flag_v_o(flag_v_o), .flag_we_o(flag_we_o)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  function automatic exp_t model(input logic [2:0] op, input logic [7:0] a, input logic ci);
    exp_t e;
    logic [8:0] w;
    e.c = ci; e.res = a; e.we = 4'b0000; e.we_tag = "R11";
    case (op)
      3'd0: begin e.res = 8'($signed(a) >>> 1); e.c = a[0]; e.tag = "R1"; end
      3'd1: begin w = {a, 1'b0}; e.res = w[7:0]; e.c = w[8]; e.tag = "R2"; end
      3'd2: begin e.res = a >> 1; e.c = a[0]; e.tag = "R3"; end
      3'd3: begin w = {a, ci}; e.res = w[7:0]; e.c = w[8]; e.tag = "R4"; end
      3'd4: begin w = {ci, a}; e.res = w[8:1]; e.c = a[0]; e.tag = "R5"; end
      3'd5: begin e.res = {a[3:0], a[7:4]}; e.tag = "R6"; e.we_tag = "R6"; end
      default: e.tag = "R11";
    endcase
    if (op < 3'd5) begin e.we = 4'b1111; e.we_tag = "R10"; end
    e.z = (e.res == 8'h00);
    e.n = e.res[7];
    e.v = e.n ^ e.c;
    return e;
  endfunction

  task automatic drive(input logic [2:0] op, input logic [7:0] a, input logic ci);
    @(negedge clk);
    op_i = op; opnd_i = a; cin_i = ci;
    q.push_back(model(op, a, ci));
  endtask

  task automatic cmp1(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
    end
  endtask

  // Monitor: inputs change at negedge, compared at following posedge
  always @(posedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      cmp1(e.tag, "result", res_o, e.res);
      cmp1(e.tag, "carry", {7'd0, flag_c_o}, {7'd0, e.c});
      cmp1("R7", "zero", {7'd0, flag_z_o}, {7'd0, e.z});
      cmp1("R8", "negative", {7'd0, flag_n_o}, {7'd0, e.n});
      cmp1("R9", "overflow", {7'd0, flag_v_o}, {7'd0, e.v});
      cmp1(e.we_tag, "mask", {4'd0, flag_we_o}, {4'd0, e.we});
    end
  end

  initial begin
    rst_n = 0; op_i = 3'd0; opnd_i = 8'h00; cin_i = 1'b0;
    // Reset state: zero inputs, R1 path yields zero result with Z set
    drive(3'd0, 8'h00, 1'b0);
    repeat (2) @(negedge clk);
    rst_n = 1;
    // Directed corners
    drive(3'd0, 8'h80, 1'b0);   // R1 sign kept: C0, N1, V1
    drive(3'd1, 8'h80, 1'b0);   // R2 result zero, C1, V1
    drive(3'd2, 8'h01, 1'b1);   // R3 carry in ignored
    drive(3'd3, 8'h80, 1'b0);   // R4 zero result, carry out set
    drive(3'd4, 8'h00, 1'b1);   // R5 carry in lands in bit 7
    drive(3'd5, 8'h3C, 1'b1);   // R6 mask clear, carry kept
    drive(3'd6, 8'hA5, 1'b1);   // R11 pass through
    drive(3'd7, 8'h00, 1'b0);   // R11 zero pass through
    // Exhaustive sweep
    for (int op = 0; op < 8; op++)
      for (int ci = 0; ci < 2; ci++)
        for (int a = 0; a < 256; a++)
          drive(3'(op), 8'(a), 1'(ci));
    @(negedge clk);
    @(negedge clk);
    drive_done = 1;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    wait (drive_done && q.size() == 0);
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule